// File: doc/BRIEF.md
# Four-way set-associative read cache

This block is a read-only cache for a 32-bit byte-addressed space. It holds 4 KB of data in one-word (4-byte) blocks, arranged as 256 sets of four ways. A requester presents an address when the cache is idle. The cache takes the block number (the address without its two offset bits) and uses it modulo the number of sets as the set index. The remaining upper bits form the tag. All four ways of that set are compared in parallel. A match vector then steers the matching way's word to the output through an AND-OR select.

On a miss the cache goes busy and raises a request on its memory side with the block-aligned address. It holds that request until memory answers. It then writes tag, data and valid into one way of the set. While the set still has an invalid way, that way is the lowest-numbered one. Once the set is full, the way comes from an external victim input. The lookup is then replayed, and the word returns flagged as not having hit.

Top module: `sac_cache`

## Requirements
- R1: After reset every way is invalid, `req_ready_o` is 1, `resp_valid_o` and `mem_req_valid_o` are 0, and the first access to any address is a miss.
- R2: The address splits into a byte offset in bits [1:0], a set index in bits [9:2] and a tag in bits [31:10]. Two addresses that differ only in the offset hit the same block.
- R3: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. When some way of the indexed set is valid and holds the address tag, the cycle after acceptance shows `resp_valid_o`=1 and `resp_hit_o`=1, with that way's word on `resp_data_o`. At most one way matches.
- R4: Four blocks with the same set index and different tags can be resident together, and all four hit.
- R5: On a miss, `mem_req_valid_o` rises two cycles after acceptance. It stays high with a constant address {tag, index, 2'b00} until a cycle with `mem_resp_valid_i`=1. `req_ready_o` is 0 for the whole time.
- R6: In the cycle after `mem_resp_valid_i`, the cache returns `resp_valid_o`=1 with `resp_hit_o`=0 and the filled word on `resp_data_o`. Later accesses to that block hit.
- R7: A fill into a set with at least one invalid way goes to the lowest-numbered invalid way. In that case `victim_way_i` has no effect.
- R8: A fill into a set whose four ways are all valid replaces the way numbered by `victim_way_i`, sampled in the lookup cycle that misses. The other three blocks stay resident.
- R9: Two blocks that share a set index, accessed in strict alternation from an empty cache, give exactly two misses, and every later access hits.
- R10: The cache gives exactly one response per accepted request, and it is ready again in the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Read request valid |
| req_addr_i | input | 32 | Byte address of the read |
| req_ready_o | output | 1 | Cache idle, request can be accepted |
| victim_way_i | input | 2 | Way to replace when the set is full |
| resp_valid_o | output | 1 | Read data valid |
| resp_hit_o | output | 1 | Response served without a fill |
| resp_data_o | output | 32 | Read word |
| mem_req_valid_o | output | 1 | Fill request to memory, held until answered |
| mem_req_addr_o | output | 32 | Block-aligned fill address |
| mem_resp_valid_i | input | 1 | Fill data valid, one cycle |
| mem_resp_data_i | input | 32 | Fill data word |

## Verification
The bench fills one set with four tags while the victim input points at way 3. If the design honoured the victim input instead of picking the lowest invalid way, blocks would overwrite each other and the later hit checks would miss. A fifth tag is then forced in with victim 2. Only the third block filled should disappear, so a way numbering that is off by one, or a fill that writes more than one way, shows up as wrong hits. Offset-only address changes and an all-ones tag at the top set catch bad field slicing. A reset in the middle of the run, followed by alternating accesses to two same-set blocks, catches valid bits that survive reset and the thrashing a direct-mapped placement would show.

// File: rtl/sac_pkg.sv
package sac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FILL   = 2'd2
  } sac_state_e;
endpackage

// File: rtl/sac_way.sv
module sac_way #(
  parameter int unsigned NUM_SETS = 256,
  parameter int unsigned TAG_W    = 22,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [TAG_W-1:0]  cmp_tag_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              valid_o,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  logic [NUM_SETS-1:0] valid_q;
  logic [TAG_W-1:0]    tag_q  [NUM_SETS];
  logic [DATA_W-1:0]   data_q [NUM_SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign valid_o = valid_q[rd_idx_i];
  assign hit_o   = valid_o && (tag_q[rd_idx_i] == cmp_tag_i);
  assign data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/sac_select.sv
module sac_select #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned DATA_W   = 32
) (
  input  logic [NUM_WAYS-1:0]             way_hit_i,
  input  logic [NUM_WAYS-1:0][DATA_W-1:0] way_data_i,
  output logic                            any_hit_o,
  output logic [DATA_W-1:0]               data_o
);
  // AND-OR steering; match vector is one-hot or zero
  always_comb begin
    data_o = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      data_o = data_o | (way_data_i[w] & {DATA_W{way_hit_i[w]}});
    end
  end

  assign any_hit_o = |way_hit_i;
endmodule

// File: rtl/sac_fill_pick.sv
module sac_fill_pick #(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] way_valid_i,
  input  logic [WAY_W-1:0]    victim_i,
  output logic [WAY_W-1:0]    way_o
);
  always_comb begin
    way_o = victim_i;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!way_valid_i[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/sac_cache.sv
module sac_cache #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_WAYS    = 4,
  parameter int unsigned NUM_SETS    = 256,
  parameter int unsigned BLOCK_BYTES = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  output logic                        req_ready_o,
  input  logic [$clog2(NUM_WAYS)-1:0] victim_way_i,
  output logic                        resp_valid_o,
  output logic                        resp_hit_o,
  output logic [DATA_W-1:0]           resp_data_o,
  output logic                        mem_req_valid_o,
  output logic [ADDR_W-1:0]           mem_req_addr_o,
  input  logic                        mem_resp_valid_i,
  input  logic [DATA_W-1:0]           mem_resp_data_i
);
  import sac_pkg::*;

  localparam int unsigned OFF_W = $clog2(BLOCK_BYTES);
  localparam int unsigned IDX_W = $clog2(NUM_SETS);
  localparam int unsigned BLK_W = ADDR_W - OFF_W;
  localparam int unsigned TAG_W = BLK_W - IDX_W;
  localparam int unsigned WAY_W = $clog2(NUM_WAYS);

  sac_state_e              state_q;
  logic [BLK_W-1:0]        blk_q;
  logic [WAY_W-1:0]        fill_way_q;
  logic                    missed_q;

  logic [IDX_W-1:0]        set_idx;
  logic [TAG_W-1:0]        set_tag;
  logic [NUM_WAYS-1:0]     way_hit;
  logic [NUM_WAYS-1:0]     way_valid;
  logic [NUM_WAYS-1:0][DATA_W-1:0] way_data;
  logic                    any_hit;
  logic [WAY_W-1:0]        pick_way;
  logic                    fill_we;
  logic                    unused_offset;

  assign unused_offset = ^req_addr_i[OFF_W-1:0];
  assign set_idx = blk_q[IDX_W-1:0];
  assign set_tag = blk_q[BLK_W-1:IDX_W];
  assign fill_we = (state_q == ST_FILL) && mem_resp_valid_i;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    sac_way #(
      .NUM_SETS (NUM_SETS),
      .TAG_W    (TAG_W),
      .DATA_W   (DATA_W)
    ) u_way (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_idx_i  (set_idx),
      .cmp_tag_i (set_tag),
      .wr_en_i   (fill_we && (fill_way_q == WAY_W'(w))),
      .wr_idx_i  (set_idx),
      .wr_tag_i  (set_tag),
      .wr_data_i (mem_resp_data_i),
      .valid_o   (way_valid[w]),
      .hit_o     (way_hit[w]),
      .data_o    (way_data[w])
    );
  end

  sac_select #(
    .NUM_WAYS (NUM_WAYS),
    .DATA_W   (DATA_W)
  ) u_select (
    .way_hit_i  (way_hit),
    .way_data_i (way_data),
    .any_hit_o  (any_hit),
    .data_o     (resp_data_o)
  );

  sac_fill_pick #(
    .NUM_WAYS (NUM_WAYS)
  ) u_pick (
    .way_valid_i (way_valid),
    .victim_i    (victim_way_i),
    .way_o       (pick_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      blk_q      <= '0;
      fill_way_q <= '0;
      missed_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          blk_q    <= req_addr_i[ADDR_W-1:OFF_W];
          missed_q <= 1'b0;
          state_q  <= ST_LOOKUP;
        end
        ST_LOOKUP: if (any_hit) begin
          state_q <= ST_IDLE;
        end else begin
          fill_way_q <= pick_way;
          missed_q   <= 1'b1;
          state_q    <= ST_FILL;
        end
        ST_FILL: if (mem_resp_valid_i) state_q <= ST_LOOKUP;  // replay after fill
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign resp_valid_o    = (state_q == ST_LOOKUP) && any_hit;
  assign resp_hit_o      = resp_valid_o && !missed_q;
  assign mem_req_valid_o = (state_q == ST_FILL);
  assign mem_req_addr_o  = {blk_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFF_W    = 2,
  parameter int unsigned NUM_WAYS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_ready_o,
  input logic                resp_valid_o,
  input logic                resp_hit_o,
  input logic                mem_req_valid_o,
  input logic [ADDR_W-1:0]   mem_req_addr_o,
  input logic                mem_resp_valid_i,
  input logic [NUM_WAYS-1:0] way_hit
);
  p_single_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(way_hit));

  p_busy_not_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  p_aligned_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_addr_o[OFF_W-1:0] == '0));

  p_req_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_resp_valid_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  p_replay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_resp_valid_i) |=> (resp_valid_o && !resp_hit_o));

  p_accept_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_resp_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !req_ready_o);

  p_ready_after_resp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> (req_ready_o && !resp_valid_o));
endmodule

bind sac_cache sac_checker #(
  .ADDR_W   (ADDR_W),
  .OFF_W    ($clog2(BLOCK_BYTES)),
  .NUM_WAYS (NUM_WAYS)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_valid_i      (req_valid_i),
  .req_ready_o      (req_ready_o),
  .resp_valid_o     (resp_valid_o),
  .resp_hit_o       (resp_hit_o),
  .mem_req_valid_o  (mem_req_valid_o),
  .mem_req_addr_o   (mem_req_addr_o),
  .mem_resp_valid_i (mem_resp_valid_i),
  .way_hit          (way_hit)
);

// File: tb/sac_cache_tb.sv
module sac_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [31:0] addr;
    logic        hit;
    logic [1:0]  victim;
  } vec_t;

  localparam int N_VEC = 26;
  localparam vec_t VECS [N_VEC] = '{
    '{32'h0000_0000, 1'b0, 2'd0},  // R1 cold miss
    '{32'h0000_0400, 1'b0, 2'd0},  // same set, other tag
    '{32'h0000_0000, 1'b1, 2'd0},
    '{32'h0000_0400, 1'b1, 2'd0},
    '{32'h0000_0002, 1'b1, 2'd0},  // R2 offset only
    '{32'h0000_0403, 1'b1, 2'd0},  // R2 offset only
    '{32'h0000_000C, 1'b0, 2'd3},  // R7 A -> way0 despite victim 3
    '{32'h0000_040C, 1'b0, 2'd3},  // R7 B -> way1
    '{32'h0000_080C, 1'b0, 2'd3},  // R7 C -> way2
    '{32'h0000_0C0C, 1'b0, 2'd3},  // R7 D -> way3
    '{32'h0000_000C, 1'b1, 2'd0},  // R4 all four resident
    '{32'h0000_040C, 1'b1, 2'd0},  // R4
    '{32'h0000_080C, 1'b1, 2'd0},  // R4
    '{32'h0000_0C0C, 1'b1, 2'd0},  // R4
    '{32'h0000_100C, 1'b0, 2'd2},  // R8 E evicts way2 (C)
    '{32'h0000_000C, 1'b1, 2'd1},  // R8 others stay
    '{32'h0000_040C, 1'b1, 2'd1},
    '{32'h0000_0C0C, 1'b1, 2'd1},
    '{32'h0000_100C, 1'b1, 2'd1},
    '{32'h0000_080C, 1'b0, 2'd0},  // R8 C gone; refill evicts A
    '{32'h0000_000C, 1'b0, 2'd1},  // R8 A gone; refill evicts B
    '{32'h0000_0C0C, 1'b1, 2'd0},
    '{32'h0000_100C, 1'b1, 2'd0},
    '{32'hFFFF_FFFC, 1'b0, 2'd0},  // R2 top set, all-ones tag
    '{32'hFFFF_FFFC, 1'b1, 2'd0},
    '{32'hFFFF_FFFD, 1'b1, 2'd0}   // R2
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_ready_o;
  logic [1:0]  victim_way_i = '0;
  logic        resp_valid_o;
  logic        resp_hit_o;
  logic [31:0] resp_data_o;
  logic        mem_req_valid_o;
  logic [31:0] mem_req_addr_o;
  logic        mem_resp_valid_i = 1'b0;
  logic [31:0] mem_resp_data_i = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sac_cache u_dut (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .req_valid_i      (req_valid_i),
    .req_addr_i       (req_addr_i),
    .req_ready_o      (req_ready_o),
    .victim_way_i     (victim_way_i),
    .resp_valid_o     (resp_valid_o),
    .resp_hit_o       (resp_hit_o),
    .resp_data_o      (resp_data_o),
    .mem_req_valid_o  (mem_req_valid_o),
    .mem_req_addr_o   (mem_req_addr_o),
    .mem_resp_valid_i (mem_resp_valid_i),
    .mem_resp_data_i  (mem_resp_data_i)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A3C_0F96;
  endfunction

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic exp_hit, input logic [1:0] vic);
    @(negedge clk_i);
    req_valid_i  = 1'b1;
    req_addr_i   = a;
    victim_way_i = vic;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (exp_hit) begin
      check_eq("R3", "hit response valid", 32'(resp_valid_o), 32'd1);
      check_eq("R3", "hit flag", 32'(resp_hit_o), 32'd1);
      check_eq("R3", "hit data", resp_data_o, mem_word(a));
    end else begin
      check_eq("R6", "no response on miss lookup", 32'(resp_valid_o), 32'd0);
      @(negedge clk_i);
      check_eq("R5", "fill request raised", 32'(mem_req_valid_o), 32'd1);
      check_eq("R5", "fill address", mem_req_addr_o, {a[31:2], 2'b00});
      @(negedge clk_i);
      check_eq("R5", "fill request held", 32'(mem_req_valid_o), 32'd1);
      check_eq("R5", "busy not ready", 32'(req_ready_o), 32'd0);
      mem_resp_valid_i = 1'b1;
      mem_resp_data_i  = mem_word(a);
      @(negedge clk_i);
      mem_resp_valid_i = 1'b0;
      mem_resp_data_i  = '0;
      check_eq("R6", "replay response valid", 32'(resp_valid_o), 32'd1);
      check_eq("R6", "replay flagged as miss", 32'(resp_hit_o), 32'd0);
      check_eq("R6", "replay data", resp_data_o, mem_word(a));
    end
    @(negedge clk_i);
    check_eq("R10", "ready after response", 32'(req_ready_o), 32'd1);
    check_eq("R10", "single response", 32'(resp_valid_o), 32'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check_eq("R1", "ready in reset", 32'(req_ready_o), 32'd1);
    check_eq("R1", "no response in reset", 32'(resp_valid_o), 32'd0);
    check_eq("R1", "no fill in reset", 32'(mem_req_valid_o), 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      access(VECS[i].addr, VECS[i].hit, VECS[i].victim);
    end

    // R1 reset clears valid state mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check_eq("R1", "idle after reset", 32'(req_ready_o), 32'd1);
    rst_ni = 1'b1;
    access(32'h0000_0C0C, 1'b0, 2'd0);   // R1 was resident, now cold

    // R9 alternating blocks in one set: two misses then hits
    for (int i = 0; i < 8; i++) begin
      access((i % 2 == 0) ? 32'h0000_0000 : 32'h0000_0400, i >= 2, 2'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule